// File: doc/BRIEF.md
# Receive Character Buffer with Line Status

This block sits between a serial receiver front end and a CPU register port. Each time the front end finishes a character, it presents the eight data bits with three per-character flags: parity error, framing error and break. The block stores the character and its flags together. The CPU pops characters through a data address and inspects receiver health through a status byte at a second address. A receiver line status interrupt is raised from the status byte when it is enabled.

There are two storage modes. With `fifoMode` high, characters queue in a first-in first-out buffer of `DEPTH` entries. With `fifoMode` low, a single holding register is used. The mode is expected to change only while the buffer is empty.

The status byte also carries two transmitter readiness bits. These come in as inputs and are returned unchanged, so one read gives software a full view of the line. The read port is combinational. `rdData` shows the value selected by `rdAddr` during the cycle, and the side effects of a read (pop, status clear) take place at the clock edge that ends a cycle with `rdEn` high.

Top module: `rx_line_status_fifo`

## Requirements
- R1: After reset the buffer is empty, status bits 0 to 4 and bit 7 read zero, and `lsIrq` is low.
- R2: `rdAddr`=0 selects the oldest character and a read there pops it; `rdAddr`=1 selects the status byte. Status bit 0 (data ready) is 1 while at least one character is stored and drops to 0 after the last one is read.
- R3: In buffer mode up to `DEPTH` characters (16 by default) are held and read out in arrival order.
- R4: In buffer mode, a character that arrives when all entries are occupied and no data read happens in that cycle is discarded. The stored characters are unchanged, and status bit 1 (overrun) reads 1 from the very next cycle.
- R5: In holding-register mode, a character that arrives while an unread one is held replaces it and sets status bit 1.
- R6: Status bit 2 (parity), bit 3 (framing) and bit 4 (break) reflect the flags of the oldest stored character only. A character's flags are shown only while that character is the oldest. Incoming flag mapping: `rxParErr`→bit 2, `rxFrmErr`→bit 3, `rxBrk`→bit 4.
- R7: A status read clears bit 1 and hides bits 2 to 4 for the character that is currently oldest.
- R8: Status bit 7 becomes 1 as soon as a character with any flag is stored. It stays 1 until a status read happens while no flagged character remains.
- R9: When a status read and a new overrun or new flagged character fall in the same cycle, the read returns the previous value and the new event's bits read 1 afterwards.
- R10: `lsIrq` is 1 exactly when `lsIntEn` is 1 and any of status bits 1 to 4 is 1.
- R11: Status bit 5 returns `txHoldEmpty` and bit 6 returns `txAllEmpty` as driven in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoMode | input | 1 | 1 = queued buffer, 0 = single holding register |
| rxValid | input | 1 | One-cycle strobe: a received character is presented |
| rxData | input | 8 | Received character |
| rxParErr | input | 1 | Parity error flag for this character |
| rxFrmErr | input | 1 | Framing error flag for this character |
| rxBrk | input | 1 | Break flag for this character |
| rdEn | input | 1 | Read strobe; side effects occur at the clock edge |
| rdAddr | input | 1 | 0 = character data, 1 = status byte |
| rdData | output | 8 | Read value for the selected address |
| txHoldEmpty | input | 1 | Transmit holding empty, returned as status bit 5 |
| txAllEmpty | input | 1 | Transmitter fully empty, returned as status bit 6 |
| lsIntEn | input | 1 | Receiver line status interrupt enable |
| lsIrq | output | 1 | Receiver line status interrupt |

## Verification
The bench fills the buffer and pushes one more flagged character. If the design accepted it, a wrapped pointer would corrupt the order or a seventeenth byte would appear. If the drop left a trace in bit 7, the discarded character's flags would have leaked into the status.

Flags are checked across pops. A design that ORs flags into sticky bits would report parity on a clean character that follows a bad one. A design that fails to re-arm on a pop would hide a later character's framing error.

In holding-register mode, a status read is issued in the same cycle as an overwriting flagged character. Clear-wins logic would lose the overrun and bit 7. The read also must return the old byte, not the new one. The gated interrupt and the pass-through transmit bits are checked directly at the ports.

// File: rtl/rxls_pkg.sv
package rxls_pkg;

  localparam int DATA_W = 8;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } errFlags_t;

  typedef struct packed {
    errFlags_t         flags;
    logic [DATA_W-1:0] data;
  } rxEntry_t;

  // strobes from control to storage
  typedef struct packed {
    logic push;       // append at tail
    logic pop;        // drop head
    logic overwrite;  // replace head in place (holding-register mode)
  } fifoCmd_t;

endpackage

// File: rtl/rxls_datapath.sv
module rxls_datapath
  import rxls_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoCmd_t         cmd,
  input  rxEntry_t         wrEntry,
  output rxEntry_t         headEntry,
  output logic [CNT_W-1:0] fillCount,
  output logic [CNT_W-1:0] errCount
);

  rxEntry_t         store [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic             incErr;
  logic             decErr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign headEntry = store[rdPtr];
  assign incErr    = (cmd.push | cmd.overwrite) & (|wrEntry.flags);
  assign decErr    = (cmd.pop  | cmd.overwrite) & (|headEntry.flags);

  // storage array, no reset needed: occupancy is tracked by fillCount
  always_ff @(posedge clk) begin
    if (cmd.push) begin
      store[wrPtr] <= wrEntry;
    end else if (cmd.overwrite) begin
      store[rdPtr] <= wrEntry;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
      errCount  <= '0;
    end else begin
      if (cmd.push) wrPtr <= nextPtr(wrPtr);
      if (cmd.pop)  rdPtr <= nextPtr(rdPtr);
      case ({cmd.push, cmd.pop})
        2'b10:   fillCount <= fillCount + CNT_W'(1);
        2'b01:   fillCount <= fillCount - CNT_W'(1);
        default: fillCount <= fillCount;
      endcase
      errCount <= errCount + CNT_W'(incErr) - CNT_W'(decErr);
    end
  end

endmodule

// File: rtl/rxls_control.sv
module rxls_control
  import rxls_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoMode,
  input  logic             rxValid,
  input  errFlags_t        rxFlags,
  input  logic             rdEn,
  input  logic             rdAddr,
  input  logic [CNT_W-1:0] fillCount,
  input  logic [CNT_W-1:0] errCount,
  input  errFlags_t        headFlags,
  input  logic             txHoldEmpty,
  input  logic             txAllEmpty,
  input  logic             lsIntEn,
  output fifoCmd_t         cmd,
  output logic [7:0]       lsrValue,
  output logic             lsIrq
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic             dataRead;
  logic             statusRead;
  logic [CNT_W-1:0] capacity;
  logic             isEmpty;
  logic             isFull;
  logic             popReq;
  logic             overrunHit;
  logic             headChange;
  logic             pushErr;
  logic             ovrErr;
  logic             headSeen;
  logic             fifoErr;
  errFlags_t        shownFlags;

  assign dataRead   = rdEn & (rdAddr == 1'b0);
  assign statusRead = rdEn & (rdAddr == 1'b1);
  assign capacity   = fifoMode ? FULL_CNT : ONE_CNT;
  assign isEmpty    = (fillCount == '0);
  assign isFull     = (fillCount >= capacity);
  assign popReq     = dataRead & ~isEmpty;

  always_comb begin
    cmd        = '0;
    overrunHit = 1'b0;
    cmd.pop    = popReq;
    if (rxValid) begin
      if (!isFull || popReq) begin
        cmd.push = 1'b1;
      end else if (fifoMode) begin
        overrunHit = 1'b1;            // new character dropped
      end else begin
        cmd.overwrite = 1'b1;         // unread character destroyed
        overrunHit    = 1'b1;
      end
    end
  end

  assign headChange = (cmd.push & isEmpty) | cmd.pop | cmd.overwrite;
  assign pushErr    = (cmd.push | cmd.overwrite) & (|rxFlags);

  // new events win over a same-cycle status read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovrErr   <= 1'b0;
      headSeen <= 1'b0;
      fifoErr  <= 1'b0;
    end else begin
      ovrErr   <= overrunHit | (ovrErr & ~statusRead);
      headSeen <= headChange ? 1'b0 : (statusRead | headSeen);
      fifoErr  <= (errCount != '0) | pushErr | (fifoErr & ~statusRead);
    end
  end

  assign shownFlags = (!isEmpty && !headSeen) ? headFlags : '0;

  assign lsrValue = {fifoErr, txAllEmpty, txHoldEmpty,
                     shownFlags.brk, shownFlags.frm, shownFlags.par,
                     ovrErr, ~isEmpty};

  assign lsIrq = lsIntEn & (ovrErr | (|shownFlags));

endmodule

// File: rtl/rx_line_status_fifo.sv
module rx_line_status_fifo
  import rxls_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fifoMode,
  input  logic       rxValid,
  input  logic [7:0] rxData,
  input  logic       rxParErr,
  input  logic       rxFrmErr,
  input  logic       rxBrk,
  input  logic       rdEn,
  input  logic       rdAddr,
  output logic [7:0] rdData,
  input  logic       txHoldEmpty,
  input  logic       txAllEmpty,
  input  logic       lsIntEn,
  output logic       lsIrq
);

  fifoCmd_t         cmd;
  rxEntry_t         inEntry;
  rxEntry_t         headEntry;
  logic [CNT_W-1:0] fillCount;
  logic [CNT_W-1:0] errCount;
  logic [7:0]       lsrValue;

  assign inEntry = {rxBrk, rxFrmErr, rxParErr, rxData};

  rxls_datapath #(.DEPTH(DEPTH)) dpI (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .wrEntry   (inEntry),
    .headEntry (headEntry),
    .fillCount (fillCount),
    .errCount  (errCount)
  );

  rxls_control #(.DEPTH(DEPTH)) ctlI (
    .clk         (clk),
    .rstN        (rstN),
    .fifoMode    (fifoMode),
    .rxValid     (rxValid),
    .rxFlags     (inEntry.flags),
    .rdEn        (rdEn),
    .rdAddr      (rdAddr),
    .fillCount   (fillCount),
    .errCount    (errCount),
    .headFlags   (headEntry.flags),
    .txHoldEmpty (txHoldEmpty),
    .txAllEmpty  (txAllEmpty),
    .lsIntEn     (lsIntEn),
    .cmd         (cmd),
    .lsrValue    (lsrValue),
    .lsIrq       (lsIrq)
  );

  assign rdData = rdAddr ? lsrValue : ((fillCount != '0) ? headEntry.data : '0);

endmodule

// File: rtl/rx_line_status_fifo_chk.sv
module rx_line_status_fifo_chk #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             fifoMode,
  input logic             rxValid,
  input logic             rdEn,
  input logic             rdAddr,
  input logic             lsIntEn,
  input logic             lsIrq,
  input logic [CNT_W-1:0] fillCount,
  input logic [4:0]       stsLow
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  // R3
  capacity_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= FULL_CNT);

  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoMode && rxValid && fillCount == FULL_CNT && !(rdEn && !rdAddr))
    |=> (fillCount == FULL_CNT) && stsLow[1]);

  // R5
  holding_overwrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoMode && rxValid && fillCount == ONE_CNT && !(rdEn && !rdAddr))
    |=> (fillCount == ONE_CNT) && stsLow[1]);

  // R7
  status_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr && !rxValid) |=> !stsLow[1]);

  // R9
  read_vs_overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr && rxValid && fifoMode && fillCount == FULL_CNT) |=> stsLow[1]);

  // R2
  last_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !rdAddr && fillCount == ONE_CNT && !rxValid) |=> !stsLow[0]);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lsIntEn |-> !lsIrq);

  // R10
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lsIntEn && stsLow[1]) |-> lsIrq);

endmodule

bind rx_line_status_fifo rx_line_status_fifo_chk #(.DEPTH(DEPTH)) chkI (
  .clk       (clk),
  .rstN      (rstN),
  .fifoMode  (fifoMode),
  .rxValid   (rxValid),
  .rdEn      (rdEn),
  .rdAddr    (rdAddr),
  .lsIntEn   (lsIntEn),
  .lsIrq     (lsIrq),
  .fillCount (fillCount),
  .stsLow    (lsrValue[4:0])
);

// File: tb/rx_line_status_fifo_tb_top.sv
module rx_line_status_fifo_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fifoMode = 1'b1;
  logic       rxValid = 1'b0;
  logic [7:0] rxData = '0;
  logic       rxParErr = 1'b0;
  logic       rxFrmErr = 1'b0;
  logic       rxBrk = 1'b0;
  logic       rdEn = 1'b0;
  logic       rdAddr = 1'b0;
  logic [7:0] rdData;
  logic       txHoldEmpty = 1'b1;
  logic       txAllEmpty = 1'b0;
  logic       lsIntEn = 1'b0;
  logic       lsIrq;

  int  testCnt = 0;
  int  failCnt = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  rx_line_status_fifo dut_i (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .rxValid(rxValid),
    .rxData(rxData), .rxParErr(rxParErr), .rxFrmErr(rxFrmErr), .rxBrk(rxBrk),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .txHoldEmpty(txHoldEmpty), .txAllEmpty(txAllEmpty),
    .lsIntEn(lsIntEn), .lsIrq(lsIrq)
  );

  // op[20:19]: 0 push, 1 data read, 2 status read; payload[18:8] = {brk,frm,par,data}; expected[7:0]
  localparam logic [20:0] VEC [17] = '{
    {2'd0, 11'h041, 8'h00},
    {2'd0, 11'h142, 8'h00},
    {2'd0, 11'h400, 8'h00},
    {2'd2, 11'h000, 8'hA1},
    {2'd1, 11'h000, 8'h41},
    {2'd2, 11'h000, 8'hA5},
    {2'd2, 11'h000, 8'hA1},
    {2'd1, 11'h000, 8'h42},
    {2'd2, 11'h000, 8'hB1},
    {2'd1, 11'h000, 8'h00},
    {2'd2, 11'h000, 8'hA0},
    {2'd2, 11'h000, 8'h20},
    {2'd0, 11'h255, 8'h00},
    {2'd2, 11'h000, 8'hA9},
    {2'd1, 11'h000, 8'h55},
    {2'd2, 11'h000, 8'hA0},
    {2'd2, 11'h000, 8'h20}
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    testCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // called at a falling edge; returns the combinational read value, ends at the next falling edge
  task automatic step(input logic pushV, input logic [10:0] pl,
                      input logic rdV, input logic addrV, output logic [7:0] got);
    rxValid  = pushV;
    rxBrk    = pl[10];
    rxFrmErr = pl[9];
    rxParErr = pl[8];
    rxData   = pl[7:0];
    rdEn     = rdV;
    rdAddr   = addrV;
    #1 got = rdData;
    @(negedge clk);
    rxValid = 1'b0;
    rdEn    = 1'b0;
  endtask

  initial begin
    logic [7:0] got;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    step(1'b0, '0, 1'b1, 1'b1, got);
    check("R1 status after reset", got, 8'h20);
    check("R1 irq after reset", {7'd0, lsIrq}, 8'h00);

    // transmit bits pass through
    txHoldEmpty = 1'b0; txAllEmpty = 1'b1;
    step(1'b0, '0, 1'b1, 1'b1, got);
    check("R11 tx bits", got, 8'h40);
    txHoldEmpty = 1'b1; txAllEmpty = 1'b0;

    // table walk: R2 R3 R6 R7 R8 in buffer mode
    for (int i = 0; i < 17; i++) begin
      logic [1:0] op;
      op = VEC[i][20:19];
      if (op == 2'd0) begin
        step(1'b1, VEC[i][18:8], 1'b0, 1'b0, got);
      end else if (op == 2'd1) begin
        step(1'b0, '0, 1'b1, 1'b0, got);
        check($sformatf("R3 table data %0d", i), got, VEC[i][7:0]);
      end else begin
        step(1'b0, '0, 1'b1, 1'b1, got);
        check($sformatf("R6 R8 table status %0d", i), got, VEC[i][7:0]);
      end
    end

    // overflow in buffer mode
    lsIntEn = 1'b1;
    for (int i = 0; i < 16; i++) step(1'b1, {3'b000, 8'(i)}, 1'b0, 1'b0, got);
    step(1'b1, 11'h1EE, 1'b0, 1'b0, got);
    check("R4 overrun irq immediate", {7'd0, lsIrq}, 8'h01);
    step(1'b0, '0, 1'b1, 1'b1, got);
    check("R4 status after drop", got, 8'h23);
    check("R10 irq cleared by status read", {7'd0, lsIrq}, 8'h00);
    for (int i = 0; i < 16; i++) begin
      step(1'b0, '0, 1'b1, 1'b0, got);
      check($sformatf("R3 R4 order %0d", i), got, 8'(i));
    end
    step(1'b0, '0, 1'b1, 1'b1, got);
    check("R2 empty after drain", got, 8'h20);

    // interrupt enable gating
    lsIntEn = 1'b0;
    step(1'b1, 11'h177, 1'b0, 1'b0, got);
    check("R10 irq masked", {7'd0, lsIrq}, 8'h00);
    lsIntEn = 1'b1;
    #1 check("R10 irq enabled", {7'd0, lsIrq}, 8'h01);
    step(1'b0, '0, 1'b1, 1'b0, got);
    check("R3 flagged data", got, 8'h77);
    step(1'b0, '0, 1'b1, 1'b1, got);
    check("R8 bit7 after drain", got, 8'hA0);
    step(1'b0, '0, 1'b1, 1'b1, got);
    check("R8 bit7 cleared", got, 8'h20);

    // holding-register mode
    fifoMode = 1'b0;
    step(1'b1, 11'h011, 1'b0, 1'b0, got);
    step(1'b0, '0, 1'b1, 1'b1, got);
    check("R2 holding ready", got, 8'h21);
    step(1'b1, 11'h222, 1'b1, 1'b1, got);
    check("R9 read returns old status", got, 8'h21);
    step(1'b0, '0, 1'b1, 1'b1, got);
    check("R5 R9 overwrite status", got, 8'hAB);
    step(1'b0, '0, 1'b1, 1'b1, got);
    check("R7 cleared by read", got, 8'hA1);
    step(1'b0, '0, 1'b1, 1'b0, got);
    check("R5 replaced data", got, 8'h22);
    step(1'b0, '0, 1'b1, 1'b1, got);
    check("R2 R8 holding drained", got, 8'hA0);
    step(1'b0, '0, 1'b1, 1'b1, got);
    check("R8 holding bit7 cleared", got, 8'h20);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule